// File: doc/BRIEF.md
# Two-Stream Interleaved Forward State-Metric Unit

This block computes the forward state metrics of a 4-state max-log-MAP trellis for a data block that has been cut into two independent halves. Subblock 0 and subblock 1 share a single add-compare-select datapath and take turns on it in alternate clock cycles. The feedback loop holds two register stages. One sits between the adders and the compare/select logic, and the other holds the normalised state metrics. Each stream's new metrics therefore reach the adders again exactly two cycles after they left. The path between any two registers covers only half of an add-compare-select. The arithmetic is not duplicated.

A free-running phase bit, brought out on `slot`, names the subblock that owns the current cycle. The upstream branch-metric source presents a word for that subblock in that cycle. It raises `in_valid` when the word is a real trellis step and raises `in_start` on the first step of a subblock. Every slot produces a result on the output two cycles later, with a valid flag, the subblock id and the step index. Only slots that carried a valid input produce a valid result. A slot without valid input leaves the metrics of its subblock unchanged.

Top module: `bip_acs_fwd`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0, every state metric on `out_metric` is 0 and `slot` is 0.
- R2: `slot` is 0 in the first cycle after reset and toggles every cycle. The input word presented in a cycle belongs to the subblock named by `slot` in that cycle.
- R3: A result appears two cycles after its input slot. In that cycle `out_valid` equals the `in_valid` of the slot and `out_id` equals the `slot` value of that slot.
- R4: Branch metric lane j sits at `in_bm[j*BW +: BW]` and is a signed two's-complement value. For a valid step, new state s (0..3) with branch b (0..1) has predecessor state p = 2*(s mod 2) + b and uses lane j = 2*s + b. The unnormalised new metric of state s is the maximum of old[p] + lane j over its two branches.
- R5: A valid step with `in_start` in a subblock-0 slot discards the stored metrics and uses the starting values 0 for state 0 and -(2^(MW-2)) for states 1 to 3.
- R6: A valid step with `in_start` in a subblock-1 slot uses starting value 0 for all four states.
- R7: After every update the new state-0 metric is subtracted from all four states. State metric s appears on `out_metric[s*MW +: MW]`, and the state-0 field is therefore always 0.
- R8: The two subblocks never affect each other's metrics. A slot with `in_valid` low leaves its subblock's metrics unchanged, and two cycles later `out_metric` shows those unchanged metrics.
- R9: `out_step` is 0 for a valid start step and otherwise one more than the previous valid step of the same subblock. It wraps modulo 2^SW.
- R10: `in_start` has no effect when `in_valid` is low. It changes neither the metrics nor the step count of the subblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The current slot carries a trellis step |
| in_start | input | 1 | First step of the subblock owning this slot |
| in_bm | input | 8*BW | Eight signed branch metrics, lane j = 2*state + branch |
| slot | output | 1 | Subblock that owns the current input cycle |
| out_valid | output | 1 | Result belongs to a valid step |
| out_id | output | 1 | Subblock of the result |
| out_step | output | SW | Step index of the result within its subblock |
| out_metric | output | 4*MW | Normalised state metrics, state s at bits s*MW |

## Verification
The assertions rely on three assumptions about the inputs. The source follows the `slot` phase. `in_valid` is low during reset. The branch metrics stay within their BW-bit signed range, so normalised metrics never wrap in MW bits. The bench derives its own phase from the reset release and checks that it agrees with `slot`. It only ever draws branch metrics from the signed BW-bit range, and its reference recursions use ordinary integers. With those limits, any truncation in the design would show up as a mismatch.

// File: rtl/bip_acs_fwd.sv
module bip_acs_fwd #(
  parameter int MW = 12,
  parameter int BW = 6,
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_start,
  input  logic [8*BW-1:0] in_bm,
  output logic            slot,
  output logic            out_valid,
  output logic            out_id,
  output logic [SW-1:0]   out_step,
  output logic [4*MW-1:0] out_metric
);
  localparam int SUMW = MW + 2;
  localparam logic signed [MW-1:0] NEGV = {2'b11, {(MW-2){1'b0}}};
  localparam logic signed [SUMW-1:0] MINS = {1'b1, {(SUMW-1){1'b0}}};

  logic ph;
  logic [SW-1:0] cnt [2];
  logic [SW-1:0] st_d, st1;
  logic v1, id1;
  logic ld;
  logic signed [MW-1:0]   met   [4];
  logic signed [MW-1:0]   src   [4];
  logic signed [SUMW-1:0] sum_d [8];
  logic signed [SUMW-1:0] sum_q [8];
  logic signed [SUMW-1:0] sel   [4];
  logic signed [SUMW-1:0] nrm   [4];

  assign slot = ph;
  assign ld   = in_valid & in_start;
  assign st_d = in_start ? '0 : cnt[ph] + SW'(1);

  for (genvar s = 0; s < 4; s++) begin : g_state
    assign src[s] = ld ? ((!ph && s != 0) ? NEGV : '0) : met[s];
    assign sel[s] = (sum_q[2*s] >= sum_q[2*s+1]) ? sum_q[2*s] : sum_q[2*s+1];
    assign nrm[s] = sel[s] - sel[0];
    assign out_metric[s*MW +: MW] = met[s];
  end

  for (genvar j = 0; j < 8; j++) begin : g_add
    localparam int S = j / 2;
    localparam int B = j % 2;
    localparam int P = 2 * (S % 2) + B;
    logic signed [BW-1:0] lane;
    assign lane = in_bm[j*BW +: BW];
    if (B == 0) begin : g_keep
      assign sum_d[j] = in_valid
        ? {{2{src[P][MW-1]}}, src[P]} + {{(SUMW-BW){lane[BW-1]}}, lane}
        : {{2{src[S][MW-1]}}, src[S]};
    end else begin : g_drop
      assign sum_d[j] = in_valid
        ? {{2{src[P][MW-1]}}, src[P]} + {{(SUMW-BW){lane[BW-1]}}, lane}
        : MINS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= 1'b0;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      v1        <= 1'b0;
      id1       <= 1'b0;
      st1       <= '0;
      out_valid <= 1'b0;
      out_id    <= 1'b0;
      out_step  <= '0;
      for (int j = 0; j < 8; j++) sum_q[j] <= '0;
      for (int s = 0; s < 4; s++) met[s] <= '0;
    end else begin
      ph <= ~ph;
      if (in_valid) cnt[ph] <= st_d;
      v1        <= in_valid;
      id1       <= ph;
      st1       <= st_d;
      out_valid <= v1;
      out_id    <= id1;
      out_step  <= st1;
      for (int j = 0; j < 8; j++) sum_q[j] <= sum_d[j];
      for (int s = 0; s < 4; s++) met[s] <= nrm[s][MW-1:0];
    end
  end
endmodule

// File: rtl/bip_acs_fwd_chk.sv
module bip_acs_fwd_chk #(
  parameter int MW = 12,
  parameter int SW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_start,
  input logic            slot,
  input logic            out_valid,
  input logic            out_id,
  input logic [SW-1:0]   out_step,
  input logic [4*MW-1:0] out_metric
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  slot_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1) |-> (slot != $past(slot)));

  // R3
  out_valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R3
  out_id_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && out_valid) |-> (out_id == $past(slot, 2)));

  // R7
  state0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_metric[MW-1:0] == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && !out_valid) |-> (out_metric == $past(out_metric, 2)));

  // R9
  start_step_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(in_valid && in_start, 2)) |-> (out_step == '0));
endmodule

bind bip_acs_fwd bip_acs_fwd_chk #(.MW(MW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
  .slot(slot), .out_valid(out_valid), .out_id(out_id),
  .out_step(out_step), .out_metric(out_metric)
);

// File: tb/sim_bip_acs_fwd.sv
module sim_bip_acs_fwd;
  localparam int MW = 12;
  localparam int BW = 6;
  localparam int SW = 8;
  localparam int NEG = -(1 << (MW - 2));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_start = 1'b0;
  logic [8*BW-1:0] in_bm = '0;
  logic slot, out_valid, out_id;
  logic [SW-1:0] out_step;
  logic [4*MW-1:0] out_metric;

  always #10 clk = ~clk;

  bip_acs_fwd #(.MW(MW), .BW(BW), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_bm(in_bm), .slot(slot), .out_valid(out_valid), .out_id(out_id),
    .out_step(out_step), .out_metric(out_metric)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit bph = 0;
  int ref_m [2][4];
  int ref_cnt [2];
  bit q_v [2];
  bit q_id [2];
  int q_st [2];
  int q_m [2][4];
  int bm [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int met_of(input int s);
    return int'($signed(out_metric[s*MW +: MW]));
  endfunction

  task automatic cyc(input bit v, input bit st);
    int nm [4];
    chk(slot == bph, "R2 slot phase", int'(slot), int'(bph));
    chk(out_valid == q_v[1], "R3 out_valid latency", int'(out_valid), int'(q_v[1]));
    if (q_v[1]) begin
      chk(out_id == q_id[1], "R3 out_id", int'(out_id), int'(q_id[1]));
      chk(int'(out_step) == q_st[1], "R9 step index", int'(out_step), q_st[1]);
    end
    for (int s = 0; s < 4; s++)
      chk(met_of(s) == q_m[1][s], q_v[1] ? "R4 state metric" : "R8 held metric",
          met_of(s), q_m[1][s]);
    in_valid = v;
    in_start = st;
    for (int j = 0; j < 8; j++) in_bm[j*BW +: BW] = BW'(bm[j]);
    if (v) begin
      if (st) begin
        for (int s = 0; s < 4; s++) ref_m[bph][s] = (bph == 0 && s != 0) ? NEG : 0;
        ref_cnt[bph] = 0;
      end else begin
        ref_cnt[bph] = ref_cnt[bph] + 1;
      end
      for (int s = 0; s < 4; s++) begin
        int a, b;
        a = ref_m[bph][2*(s%2)] + bm[2*s];
        b = ref_m[bph][2*(s%2)+1] + bm[2*s+1];
        nm[s] = (a > b) ? a : b;
      end
      for (int s = 0; s < 4; s++) ref_m[bph][s] = nm[s] - nm[0];
    end
    q_v[1] = q_v[0];
    q_id[1] = q_id[0];
    q_st[1] = q_st[0];
    for (int s = 0; s < 4; s++) q_m[1][s] = q_m[0][s];
    q_v[0] = v;
    q_id[0] = bph;
    q_st[0] = ref_cnt[bph] % (1 << SW);
    for (int s = 0; s < 4; s++) q_m[0][s] = ref_m[bph][s];
    bph = ~bph;
    @(negedge clk);
  endtask

  task automatic rnd_bm();
    for (int j = 0; j < 8; j++) bm[j] = int'($urandom_range(0, 63)) - 32;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      ref_cnt[i] = 0;
      q_v[i] = 0;
      q_id[i] = 0;
      q_st[i] = 0;
      for (int s = 0; s < 4; s++) begin
        ref_m[i][s] = 0;
        q_m[i][s] = 0;
      end
    end
    for (int j = 0; j < 8; j++) bm[j] = 0;
    repeat (4) @(negedge clk);
    // R1: held in reset
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(out_metric == '0, "R1 metrics in reset", int'(out_metric[MW +: MW]), 0);
    rst = 1'b0;
    // R1: first cycle after release
    chk(slot == 1'b0, "R1 slot after reset", int'(slot), 0);

    // R4 R5 R6: both subblocks start, run back to back
    for (int k = 0; k < 40; k++) begin
      rnd_bm(); cyc(1, k < 2);
    end
    // R8: random bubbles, occasional restarts
    for (int k = 0; k < 200; k++) begin
      rnd_bm(); cyc($urandom_range(0, 9) < 7, $urandom_range(0, 19) == 0);
    end
    // R10: start without valid is ignored
    for (int k = 0; k < 6; k++) begin
      rnd_bm(); cyc(0, 1);
    end
    for (int k = 0; k < 4; k++) begin
      rnd_bm(); cyc(1, 0);
    end
    // R4: lane sweep with extreme values, both polarities, both subblocks
    for (int ln = 0; ln < 8; ln++)
      for (int pol = 0; pol < 2; pol++)
        for (int sb = 0; sb < 2; sb++) begin
          for (int j = 0; j < 8; j++) bm[j] = pol ? 31 : -32;
          bm[ln] = pol ? -32 : 31;
          cyc(1, 0);
        end
    // R6 R8: restart subblock 1 only while subblock 0 runs on
    for (int k = 0; k < 20; k++) begin
      rnd_bm(); cyc(1, (k == 5));
    end
    // R5: restart subblock 0 only
    for (int k = 0; k < 10; k++) begin
      rnd_bm(); cyc(1, (k == 2));
    end
    // R9: run long enough to wrap the step index
    for (int k = 0; k < 600; k++) begin
      rnd_bm(); cyc(1, 0);
    end
    in_valid = 0;
    for (int k = 0; k < 4; k++) cyc(0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule